// File: doc/BRIEF.md
# Power-Good and Thermal Supervisor

This block decides, from a handful of digital status inputs, whether a boost regulator's power-good pin should be held low, and whether the die is hot enough to require a thermal shutdown. The power-good pin is open-drain. The block's output therefore says "pull the pin low" (not good) or "release it" (good). Power-good is granted once a soft-start sequence completes without a fault. It is withdrawn by any fault, and it also serves as an early warning. Two conditions pull it low: a rectifier current limit that persists for a configured number of microsecond ticks, and a die-temperature warning with hysteresis.

Four comparator flags arrive from an analog temperature sensor, one each for the die being above 120 °C, 100 °C, 150 °C and 130 °C. Two hysteresis trackers use them. The warning tracker trips at 120 and releases below 100. The shutdown tracker trips at 150 and releases below 130. The shutdown request goes to the sequencer. A microsecond tick paces the current-limit qualifier, so the block runs on any system clock.

Top module: `pwrok_thermal_sup`

## Requirements
- R1: After a synchronous reset, `pg_pull_low` is 1 and `therm_sd_req` is 0.
- R2: A `ss_done` strobe sampled with `fault_act` low and no alert active sets `pg_pull_low` to 0 on that same clock edge. Without a prior strobe, `pg_pull_low` stays 1.
- R3: `fault_act` high at an edge makes `pg_pull_low` 1 after that edge. Once the fault ends, `pg_pull_low` stays 1 until another `ss_done` strobe.
- R4: When `ss_done` and `fault_act` are both high at the same edge, the fault wins: `pg_pull_low` is 1 and the strobe does not arm the block.
- R5: While `ilim_active` stays high, `us_tick` pulses are counted. The edge that samples the 64th (ILIM_US) tick is followed one edge later by `pg_pull_low` = 1. A low `ilim_active` clears the count, and ticks seen while it is low have no effect.
- R6: `temp_above_120` high sets a warning one edge later. The warning holds while `temp_above_100` is high and clears on the edge after both flags are low. While the warning is set, `pg_pull_low` is 1.
- R7: When the current-limit or temperature warning clears, `pg_pull_low` returns to 0 with no new `ss_done`, provided no fault occurred since the last accepted strobe.
- R8: `therm_sd_req` becomes 1 on the edge after `temp_above_150` is high. It holds while `temp_above_130` is high and drops on the edge after both flags are low. While it is 1, `pg_pull_low` is 1.
- R9: `pg_pull_low` is a registered output: 1 means drive the open-drain pin low (not good), 0 means release it (good).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| ss_done | input | 1 | Soft-start completed successfully (strobe) |
| fault_act | input | 1 | A sequencer fault is active |
| ilim_active | input | 1 | Rectifier current limit is engaged |
| temp_above_120 | input | 1 | Die above 120 °C comparator |
| temp_above_100 | input | 1 | Die above 100 °C comparator |
| temp_above_150 | input | 1 | Die above 150 °C comparator |
| temp_above_130 | input | 1 | Die above 130 °C comparator |
| pg_pull_low | output | 1 | 1 = pull power-good pin low |
| therm_sd_req | output | 1 | Thermal shutdown request |

## Verification
Two events can land on the same edge: a soft-start completion strobe and a fault. Both can also coincide with a warning that is just clearing. The bench drives `ss_done` and `fault_act` together on purpose, and also raises them at random, independently, so they sometimes collide. A reference model computed in the bench judges the result. It requires the fault to win and the block to stay disarmed, so a later clearing of a warning must not release power-good. A current-limit count that reaches its limit on the same edge as a strobe is provoked the same way. It is judged by requiring power-good to stay low one edge later.

// File: rtl/pgsup_pkg.sv
package pgsup_pkg;

    localparam int unsigned ILIM_US_DEFAULT = 64;
    localparam int unsigned N_THERM         = 2;
    localparam int unsigned CH_WARN         = 0;
    localparam int unsigned CH_SHDN         = 1;

    // Inputs of one hysteresis tracker: trip threshold and hold threshold
    typedef struct packed {
        logic trip;
        logic hold;
    } hyst_in_t;

    // Conditions that veto power-good on top of arming
    typedef struct packed {
        logic ovl;
        logic warm;
        logic shdn;
    } alert_t;

    typedef enum logic {
        ARM_IDLE  = 1'b0,
        ARM_READY = 1'b1
    } arm_e;

    function automatic logic hyst_next(logic cur, hyst_in_t in);
        return in.trip | (cur & in.hold);
    endfunction

    function automatic arm_e arm_next_f(arm_e cur, logic strobe, logic fault);
        if (fault)       return ARM_IDLE;
        else if (strobe) return ARM_READY;
        else             return cur;
    endfunction

endpackage

// File: rtl/pgsup_ilim_qual.sv
module pgsup_ilim_qual #(
    parameter int unsigned LIMIT_US = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic flag,
    output logic sustained
);
    localparam int unsigned CW = $clog2(LIMIT_US + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT_US);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !flag) begin
            cnt <= '0;
        end else if (tick && cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sustained = flag && (cnt == CMAX);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CMAX);
    p_drop_clears_r5: assert property (@(posedge clk) disable iff (rst)
        !flag |=> cnt == '0);
    p_no_tick_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (flag && !tick) |=> (cnt == $past(cnt) || !flag));

endmodule

// File: rtl/pgsup_hyst.sv
module pgsup_hyst
    import pgsup_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hyst_in_t thr,
    output logic     hot
);
    always_ff @(posedge clk) begin
        if (rst) hot <= 1'b0;
        else     hot <= hyst_next(hot, thr);
    end

    // R6 for the warning channel, R8 for the shutdown channel
    p_hyst_trip_r6: assert property (@(posedge clk) disable iff (rst)
        thr.trip |=> hot);
    p_hyst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (hot && thr.hold) |=> hot);
    p_hyst_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!thr.trip && !thr.hold) |=> !hot);

endmodule

// File: rtl/pgsup_arbiter.sv
module pgsup_arbiter
    import pgsup_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ss_done,
    input  logic   fault_act,
    input  alert_t alerts,
    output logic   pg_pull_low
);
    arm_e arm_q, arm_d;
    logic good;

    always_comb begin
        arm_d = arm_next_f(arm_q, ss_done, fault_act);
        good  = (arm_d == ARM_READY) && !(|alerts) && !fault_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q       <= ARM_IDLE;
            pg_pull_low <= 1'b1;
        end else begin
            arm_q       <= arm_d;
            pg_pull_low <= !good;
        end
    end

    p_fault_pulls_r3: assert property (@(posedge clk) disable iff (rst)
        fault_act |=> pg_pull_low);
    p_fault_disarms_r4: assert property (@(posedge clk) disable iff (rst)
        fault_act |=> arm_q == ARM_IDLE);
    p_alert_pulls_r6: assert property (@(posedge clk) disable iff (rst)
        (|alerts) |=> pg_pull_low);
    p_release_armed_r2: assert property (@(posedge clk) disable iff (rst)
        !pg_pull_low |-> arm_q == ARM_READY);

endmodule

// File: rtl/pwrok_thermal_sup.sv
module pwrok_thermal_sup
    import pgsup_pkg::*;
#(
    parameter int unsigned ILIM_US = ILIM_US_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic ss_done,
    input  logic fault_act,
    input  logic ilim_active,
    input  logic temp_above_120,
    input  logic temp_above_100,
    input  logic temp_above_150,
    input  logic temp_above_130,
    output logic pg_pull_low,
    output logic therm_sd_req
);
    hyst_in_t            thr   [N_THERM];
    logic [N_THERM-1:0]  hot;
    logic                ovl;
    alert_t              alerts;

    assign thr[CH_WARN] = '{trip: temp_above_120, hold: temp_above_100};
    assign thr[CH_SHDN] = '{trip: temp_above_150, hold: temp_above_130};

    pgsup_ilim_qual #(.LIMIT_US(ILIM_US)) u_ilim (
        .clk       (clk),
        .rst       (rst),
        .tick      (us_tick),
        .flag      (ilim_active),
        .sustained (ovl)
    );

    for (genvar g = 0; g < N_THERM; g++) begin : g_therm
        pgsup_hyst u_hyst (
            .clk (clk),
            .rst (rst),
            .thr (thr[g]),
            .hot (hot[g])
        );
    end

    assign alerts = '{ovl: ovl, warm: hot[CH_WARN], shdn: hot[CH_SHDN]};
    assign therm_sd_req = hot[CH_SHDN];

    pgsup_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .ss_done     (ss_done),
        .fault_act   (fault_act),
        .alerts      (alerts),
        .pg_pull_low (pg_pull_low)
    );

    p_sd_trip_r8: assert property (@(posedge clk) disable iff (rst)
        temp_above_150 |=> therm_sd_req);
    p_sd_pulls_pg_r8: assert property (@(posedge clk) disable iff (rst)
        therm_sd_req |=> pg_pull_low);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pg_pull_low && !therm_sd_req));

endmodule

// File: tb/test_pwrok_thermal_sup.sv
module test_pwrok_thermal_sup;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 0, ss_done = 0, fault_act = 0, ilim_active = 0;
    logic t120 = 0, t100 = 0, t150 = 0, t130 = 0;
    logic pg_pull_low, therm_sd_req;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwrok_thermal_sup i_pwrok_thermal_sup (
        .clk(clk), .rst(rst), .us_tick(us_tick), .ss_done(ss_done),
        .fault_act(fault_act), .ilim_active(ilim_active),
        .temp_above_120(t120), .temp_above_100(t100),
        .temp_above_150(t150), .temp_above_130(t130),
        .pg_pull_low(pg_pull_low), .therm_sd_req(therm_sd_req)
    );

    // Reference model derived from the requirements
    int  m_ticks;
    bit  m_armed, m_warn, m_sd, m_pl;

    always @(posedge clk) begin
        bit overload, new_armed;
        if (rst) begin
            m_ticks = 0; m_armed = 0; m_warn = 0; m_sd = 0; m_pl = 1;
        end else begin
            overload  = ilim_active && (m_ticks >= 64);
            new_armed = fault_act ? 0 : (ss_done ? 1 : m_armed);
            m_pl      = !(new_armed && !overload && !m_warn && !m_sd && !fault_act);
            m_armed   = new_armed;
            if (!ilim_active) m_ticks = 0;
            else if (us_tick && m_ticks < 64) m_ticks++;
            m_warn = t120 ? 1 : (t100 ? m_warn : 0);
            m_sd   = t150 ? 1 : (t130 ? m_sd : 0);
        end
    end

    task automatic check(input string req, input bit got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_both(input string req);
        check(req, pg_pull_low, m_pl, "pg_pull_low");
        check(req, therm_sd_req, m_sd, "therm_sd_req");
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        us_tick = 0; ss_done = 0; fault_act = 0; ilim_active = 0;
        t120 = 0; t100 = 0; t150 = 0; t130 = 0;
    endtask

    task automatic arm();
        ss_done = 1; step(); ss_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 0;
        @(negedge clk);
        check("R1", pg_pull_low, 1'b1, "pg after reset");
        check("R1", therm_sd_req, 1'b0, "sd after reset");
        step(); step();
        check("R2", pg_pull_low, 1'b1, "no strobe keeps pg low");

        // R2: strobe releases power-good on the capturing edge
        arm();
        check("R2", pg_pull_low, 1'b0, "released by ss_done");

        // R3: fault pulls low, stays low after the fault ends
        fault_act = 1; step(); fault_act = 0;
        check("R3", pg_pull_low, 1'b1, "fault pulls low");
        repeat (4) step();
        check("R3", pg_pull_low, 1'b1, "stays low w/o new strobe");
        arm();
        check("R3", pg_pull_low, 1'b0, "rearm after fault");

        // R4: coincident strobe and fault
        ss_done = 1; fault_act = 1; step(); ss_done = 0; fault_act = 0;
        check("R4", pg_pull_low, 1'b1, "fault wins over strobe");
        step();
        check("R4", pg_pull_low, 1'b1, "not armed afterwards");
        arm();

        // R5: 63 ticks keep good, 64th trips one edge later
        ilim_active = 1; us_tick = 1;
        repeat (63) step();
        check("R5", pg_pull_low, 1'b0, "63 ticks no trip");
        step();
        check("R5", pg_pull_low, 1'b0, "64th tick edge");
        step();
        check("R5", pg_pull_low, 1'b1, "trip after 64 ticks");
        // R7: clears back to good without new strobe
        ilim_active = 0; us_tick = 0; step();
        check("R7", pg_pull_low, 1'b0, "ovl clear returns good");
        // R5: drop restarts count; ticks while low ignored
        ilim_active = 1; us_tick = 1; repeat (40) step();
        ilim_active = 0; repeat (30) step();
        ilim_active = 1; repeat (40) step();
        check("R5", pg_pull_low, 1'b0, "count restarted on drop");
        us_tick = 0; repeat (50) step();
        check("R5", pg_pull_low, 1'b0, "no ticks no count");
        ilim_active = 0; step();

        // R6: thermal warning hysteresis
        t120 = 1; t100 = 1; step();
        check("R6", pg_pull_low, 1'b0, "warn registered one edge");
        t120 = 0; step();
        check("R6", pg_pull_low, 1'b1, "warn pulls low");
        repeat (5) step();
        check("R6", pg_pull_low, 1'b1, "held above 100");
        t100 = 0; step(); step();
        check("R7", pg_pull_low, 1'b0, "warn cleared, good again");
        // R7: fault during warning requires a new strobe
        t120 = 1; step(); t120 = 0; t100 = 1;
        fault_act = 1; step(); fault_act = 0;
        t100 = 0; repeat (3) step();
        check("R7", pg_pull_low, 1'b1, "fault during warn needs strobe");
        arm();
        check("R7", pg_pull_low, 1'b0, "strobe after fault");

        // R8: shutdown hysteresis
        t150 = 1; t130 = 1; step(); t150 = 0;
        check("R8", therm_sd_req, 1'b1, "sd set");
        repeat (3) step();
        check("R8", therm_sd_req, 1'b1, "sd held above 130");
        check("R8", pg_pull_low, 1'b1, "pg low during sd");
        t130 = 0; step();
        check("R8", therm_sd_req, 1'b0, "sd released");
        step();
        check("R9", pg_pull_low, 1'b0, "release encoding 0 = good");

        // Random phase mixed with the model
        idle_inputs();
        for (int i = 0; i < 4000; i++) begin
            us_tick   = ($urandom % 3) == 0;
            ss_done   = ($urandom % 20) == 0;
            fault_act = ($urandom % 40) == 0;
            if (($urandom % 100) < 3) ilim_active = ~ilim_active;
            if (($urandom % 8) == 0) ilim_active = ilim_active | (($urandom % 4) != 0);
            t120 = ($urandom % 60) == 0;
            if (($urandom % 30) == 0) t100 = ~t100;
            t150 = ($urandom % 120) == 0;
            if (($urandom % 30) == 0) t130 = ~t130;
            if (i % 500 == 7) begin ss_done = 1; fault_act = 1; end
            step();
            check_both(i % 2 ? "R5" : "R6");
        end
        idle_inputs();
        rst = 1; step(); rst = 0;
        check("R1", pg_pull_low, 1'b1, "reset again");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule